// File: doc/BRIEF.md
# Fetch-Stage Loop Buffer

This block is a small instruction store that sits beside the fetch stage. While fetch runs along a straight line of code, every returned instruction is written into the buffer together with its word address. The buffer therefore always holds one contiguous, ordered window of the most recent sequential fetches. It describes that window by the address of its oldest entry and an entry count, and it needs no tag on each line.

When a branch resolves, its target is presented on the lookup port. If the target lies inside the window, the lookup reports a hit in the same cycle. Starting with the next cycle, the buffer replays instructions from the target onward, one per cycle, with no main-memory access. A branch back into the window restarts the replay, so a loop whose body fits in the buffer is fetched from memory only once. When the replay hands out the newest buffered entry, it flags the last word so that fetch can fall back to memory. A flush empties the window in one cycle.

Top module: `fetch_loop_buf`

## Requirements
- R1: The window holds at most DEPTH entries (16 by default). A sequential fill into a full window drops the oldest entry, and the window base moves up by one.
- R2: A fill is sequential when its word address equals base plus count. It is then appended behind the newest entry, so entries stay in fetch order. Addresses step by one per instruction and wrap modulo 2^AW.
- R3: A fill into an empty window, or a fill whose address is not sequential, discards the old contents. It restarts the window with that address as base and a count of one.
- R4: lkp_hit is combinational in the cycle of the lookup. It is 1 exactly when lkp_valid is 1, flush is 0 and (lkp_addr - base) modulo 2^AW is less than count.
- R5: In the cycle after a hit, rd_valid is 1, rd_addr equals the looked-up target and rd_instr is the instruction that was filled at that address.
- R6: While replaying with no lookup and no flush, each following cycle presents the next address (rd_addr plus one) together with its buffered instruction.
- R7: rd_last is 1 exactly in a cycle that presents the newest entry of the window. If no hit occurs in that cycle, rd_valid is 0 in the next cycle.
- R8: A hit during replay restarts the replay at the new target in the next cycle. A lookup that misses during replay ends the replay in the next cycle.
- R9: A fill is ignored, with no change to the window, in any cycle where the replay is active or a lookup hits.
- R10: flush empties the window at the next edge and ends any replay. A lookup in the flush cycle reports a miss, and a fill in the flush cycle is ignored.
- R11: After reset the window is empty, rd_valid and rd_last are 0, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Fetch stage delivers an instruction this cycle |
| fill_addr | input | AW | Word address of the delivered instruction |
| fill_instr | input | IW | Delivered instruction word |
| flush | input | 1 | Empty the window and stop any replay |
| lkp_valid | input | 1 | A resolved branch target is presented |
| lkp_addr | input | AW | Branch target word address |
| lkp_hit | output | 1 | Target lies inside the buffered window |
| rd_valid | output | 1 | Replay output is valid |
| rd_addr | output | AW | Address of the replayed instruction |
| rd_instr | output | IW | Replayed instruction word |
| rd_last | output | 1 | Replayed instruction is the newest buffered entry |

## Verification
The bench fills short runs and then probes targets just below the base, at the base, in the middle, at the newest entry and one past it. These probes separate a correct range compare from off-by-one and signed-compare errors. It also fills well beyond the depth and probes the first evicted address, which shows that the window slides rather than stopping or wrapping its contents. Loop-style lookups during replay, and fills that collide with a replay, a hit or a flush, tell the restart, end and freeze rules apart. A run of sequential addresses across the top of the address space checks that base and count arithmetic wraps correctly.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

  // What a fill does to the window in a given cycle.
  typedef enum logic [1:0] {
    FILL_NONE    = 2'd0,
    FILL_RESTART = 2'd1,
    FILL_APPEND  = 2'd2,
    FILL_SHIFT   = 2'd3
  } fill_op_e;

endpackage

// File: rtl/lbuf_store.sv
module lbuf_store #(
  parameter int DEPTH = 16,
  parameter int IW    = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [IW-1:0]   wdata,
  input  logic [IDXW-1:0] ridx,
  output logic [IW-1:0]   rdata
);

  logic [IW-1:0] row [DEPTH];

  // One data register per slot, each with its own write enable; no reset on data.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic          slot_en;
    logic [IW-1:0] slot_q;

    assign slot_en = we && (widx == IDXW'(g));

    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= wdata;
    end

    assign row[g] = slot_q;
  end

  assign rdata = row[ridx];

endmodule

// File: rtl/lbuf_window.sv
module lbuf_window
  import lbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_valid,
  input  logic [AW-1:0]   fill_addr,
  input  logic            replay_busy,
  input  logic            flush,
  input  logic            lkp_valid,
  input  logic [AW-1:0]   lkp_addr,
  output logic            lkp_hit,
  output logic [IDXW-1:0] lkp_off,
  output logic [AW-1:0]   base_q,
  output logic [CNTW-1:0] cnt_q,
  output logic [IDXW-1:0] head_q,
  output logic            we,
  output logic [IDXW-1:0] widx
);

  logic [AW-1:0]   diff;
  logic            seq;
  fill_op_e        op;
  logic [AW-1:0]   base_n;
  logic [CNTW-1:0] cnt_n;
  logic [IDXW-1:0] head_n;
  logic            win_en;

  // Range check: one subtract and one compare, no per-line tags.
  always_comb begin
    diff    = lkp_addr - base_q;
    lkp_hit = lkp_valid && !flush && (diff < AW'(cnt_q));
    lkp_off = diff[IDXW-1:0];
  end

  // Decide what this cycle's fill does to the window.
  always_comb begin
    seq = (cnt_q != '0) && (fill_addr == base_q + AW'(cnt_q));
    if (!fill_valid || flush || replay_busy || lkp_hit) op = FILL_NONE;
    else if (!seq)                                       op = FILL_RESTART;
    else if (cnt_q < CNTW'(DEPTH))                       op = FILL_APPEND;
    else                                                 op = FILL_SHIFT;
  end

  // Next state of the window.
  always_comb begin
    base_n = base_q;
    cnt_n  = cnt_q;
    head_n = head_q;
    widx   = head_q;
    unique case (op)
      FILL_RESTART: begin
        base_n = fill_addr;
        cnt_n  = CNTW'(1);
        head_n = '0;
        widx   = '0;
      end
      FILL_APPEND: begin
        cnt_n = cnt_q + CNTW'(1);
        widx  = head_q + cnt_q[IDXW-1:0];
      end
      FILL_SHIFT: begin
        widx   = head_q;
        head_n = head_q + IDXW'(1);
        base_n = base_q + AW'(1);
      end
      default: ;
    endcase
    if (flush) cnt_n = '0;
    we     = (op != FILL_NONE);
    win_en = we || flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      head_q <= '0;
    end else if (win_en) begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      head_q <= head_n;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(DEPTH)); // R1

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0)); // R10

  AST_SHIFT_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush && !replay_busy && !lkp_hit && (cnt_q == CNTW'(DEPTH)) &&
     (fill_addr == base_q + AW'(DEPTH))) |=> (cnt_q == CNTW'(DEPTH)) && (base_q == $past(base_q) + AW'(1))); // R1

endmodule

// File: rtl/lbuf_replay.sv
module lbuf_replay #(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            lkp_valid,
  input  logic            lkp_hit,
  input  logic [IDXW-1:0] lkp_off,
  input  logic [CNTW-1:0] cnt_q,
  output logic            active_q,
  output logic [IDXW-1:0] off_q,
  output logic            last
);

  logic            active_n;
  logic [IDXW-1:0] off_n;
  logic            rp_en;

  assign last = active_q && ((CNTW'(off_q) + CNTW'(1)) == cnt_q);

  always_comb begin
    active_n = active_q;
    off_n    = off_q;
    if (flush) begin
      active_n = 1'b0;
    end else if (lkp_hit) begin
      active_n = 1'b1;
      off_n    = lkp_off;
    end else if (lkp_valid) begin
      active_n = 1'b0;
    end else if (active_q) begin
      if (last) active_n = 1'b0;
      else      off_n    = off_q + IDXW'(1);
    end
    rp_en = flush || lkp_valid || active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      off_q    <= '0;
    end else if (rp_en) begin
      active_q <= active_n;
      off_q    <= off_n;
    end
  end

  AST_HIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |=> active_q && (off_q == $past(lkp_off))); // R5

  AST_LAST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !lkp_valid) |=> !active_q); // R7

  AST_MISS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && !lkp_hit) |=> !active_q); // R8

endmodule

// File: rtl/fetch_loop_buf.sv
module fetch_loop_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int IW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_addr,
  input  logic [IW-1:0] fill_instr,
  input  logic          flush,
  input  logic          lkp_valid,
  input  logic [AW-1:0] lkp_addr,
  output logic          lkp_hit,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  output logic [IW-1:0] rd_instr,
  output logic          rd_last
);

  localparam int IDXW = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [IDXW-1:0] lkp_off;
  logic [AW-1:0]   base_q;
  logic [CNTW-1:0] cnt_q;
  logic [IDXW-1:0] head_q;
  logic            we;
  logic [IDXW-1:0] widx;
  logic            active_q;
  logic [IDXW-1:0] off_q;
  logic            last;
  logic [IDXW-1:0] ridx;

  lbuf_window #(.DEPTH(DEPTH), .AW(AW)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_valid  (fill_valid),
    .fill_addr   (fill_addr),
    .replay_busy (active_q),
    .flush       (flush),
    .lkp_valid   (lkp_valid),
    .lkp_addr    (lkp_addr),
    .lkp_hit     (lkp_hit),
    .lkp_off     (lkp_off),
    .base_q      (base_q),
    .cnt_q       (cnt_q),
    .head_q      (head_q),
    .we          (we),
    .widx        (widx)
  );

  lbuf_replay #(.DEPTH(DEPTH)) u_rp (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lkp_valid (lkp_valid),
    .lkp_hit   (lkp_hit),
    .lkp_off   (lkp_off),
    .cnt_q     (cnt_q),
    .active_q  (active_q),
    .off_q     (off_q),
    .last      (last)
  );

  assign ridx = head_q + off_q;

  lbuf_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
    .clk   (clk),
    .we    (we),
    .widx  (widx),
    .wdata (fill_instr),
    .ridx  (ridx),
    .rdata (rd_instr)
  );

  assign rd_valid = active_q;
  assign rd_addr  = base_q + AW'(off_q);
  assign rd_last  = last;

  AST_REPLAY_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !flush) |=> $stable(base_q) && $stable(cnt_q)); // R9

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last && !lkp_valid && !flush) |=> rd_valid && (rd_addr == $past(rd_addr) + AW'(1))); // R6

endmodule

// File: tb/sim_fetch_loop_buf.sv
`timescale 1ns/1ps
module sim_fetch_loop_buf;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fill_valid;
  logic [31:0] fill_addr;
  logic [31:0] fill_instr;
  logic        flush;
  logic        lkp_valid;
  logic [31:0] lkp_addr;
  logic        lkp_hit;
  logic        rd_valid;
  logic [31:0] rd_addr;
  logic [31:0] rd_instr;
  logic        rd_last;

  int checks = 0;
  int errors = 0;
  int gen    = 0;

  // Behavioural reference: a queue of (address, instruction) plus a replay cursor.
  logic [31:0] qa[$];
  logic [31:0] qi[$];
  bit          m_act = 1'b0;
  int          m_off = 0;

  always #2 clk = ~clk;

  fetch_loop_buf u0 (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_instr(fill_instr), .flush(flush), .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .lkp_hit(lkp_hit), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_instr(rd_instr),
    .rd_last(rd_last)
  );

  function automatic bit m_hit(bit lv, logic [31:0] la, bit fl);
    if (!lv || fl || qa.size() == 0) return 1'b0;
    return (la - qa[0]) < 32'(qa.size());
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    bit exp_last;
    cmp(tag, "lkp_hit", 32'(lkp_hit), 32'(m_hit(lkp_valid, lkp_addr, flush)));
    cmp(tag, "rd_valid", 32'(rd_valid), 32'(m_act));
    exp_last = m_act && (m_off == qa.size() - 1);
    cmp(tag, "rd_last", 32'(rd_last), 32'(exp_last));
    if (m_act) begin
      cmp(tag, "rd_addr", rd_addr, qa[m_off]);
      cmp(tag, "rd_instr", rd_instr, qi[m_off]);
    end
  endtask

  task automatic model_step(bit fv, logic [31:0] fa, logic [31:0] fi,
                            bit lv, logic [31:0] la, bit fl);
    bit h;
    bit fok;
    h   = m_hit(lv, la, fl);
    fok = fv && !fl && !m_act && !h;
    if (fl) m_act = 1'b0;
    else if (h) begin
      m_act = 1'b1;
      m_off = int'(la - qa[0]);
    end else if (lv) m_act = 1'b0;
    else if (m_act) begin
      if (m_off == qa.size() - 1) m_act = 1'b0;
      else m_off++;
    end
    if (fok) begin
      if (qa.size() == 0 || fa != qa[0] + 32'(qa.size())) begin
        qa.delete();
        qi.delete();
      end else if (qa.size() == 16) begin
        void'(qa.pop_front());
        void'(qi.pop_front());
      end
      qa.push_back(fa);
      qi.push_back(fi);
    end
    if (fl) begin
      qa.delete();
      qi.delete();
    end
  endtask

  task automatic cyc(bit fv, logic [31:0] fa, bit lv, logic [31:0] la, bit fl, string tag);
    logic [31:0] fi;
    @(negedge clk);
    gen++;
    fi         = {8'(gen), fa[23:0]};
    fill_valid = fv;
    fill_addr  = fa;
    fill_instr = fi;
    lkp_valid  = lv;
    lkp_addr   = la;
    flush      = fl;
    #1;
    check_outputs(tag);
    @(posedge clk);
    model_step(fv, fa, fi, lv, la, fl);
  endtask

  task automatic fill_run(logic [31:0] start, int n, string tag);
    for (int k = 0; k < n; k++) cyc(1'b1, start + 32'(k), 1'b0, '0, 1'b0, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) cyc(1'b0, '0, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic look(logic [31:0] a, string tag);
    cyc(1'b0, '0, 1'b1, a, 1'b0, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fill_valid = 1'b0; fill_addr = '0; fill_instr = '0;
    flush = 1'b0; lkp_valid = 1'b0; lkp_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: empty after reset, every lookup misses
    look(32'h0, "R11");
    look(32'h100, "R11");
    idle(1, "R11");
    // R2: sequential fill in order, then R4/R5/R6/R7 replay to the end
    fill_run(32'h100, 8, "R2");
    look(32'h103, "R4");
    idle(6, "R6");
    look(32'h0FF, "R4");
    look(32'h108, "R4");
    look(32'h107, "R7");
    idle(2, "R7");
    // R1: overfill; window slides to 0x10C..0x11B
    fill_run(32'h108, 20, "R1");
    look(32'h10B, "R1");
    look(32'h10C, "R1");
    idle(17, "R1");
    // R8: loop back during replay, then a miss ends it
    look(32'h115, "R8");
    idle(3, "R8");
    look(32'h112, "R8");
    idle(2, "R8");
    look(32'h200, "R8");
    idle(1, "R8");
    // R9: fill with a hitting lookup, and fill during replay, are ignored
    cyc(1'b1, 32'h11C, 1'b1, 32'h118, 1'b0, "R9");
    cyc(1'b1, 32'h11C, 1'b0, '0, 1'b0, "R9");
    idle(4, "R9");
    look(32'h11C, "R9");
    look(32'h11B, "R9");
    idle(1, "R9");
    // R3: non-sequential fill restarts the window
    fill_run(32'h400, 1, "R3");
    look(32'h10C, "R3");
    look(32'h400, "R3");
    idle(2, "R3");
    fill_run(32'h401, 5, "R3");
    // R10: flush with lookup misses, ends replay, blocks a fill
    look(32'h401, "R10");
    idle(1, "R10");
    cyc(1'b0, '0, 1'b1, 32'h402, 1'b1, "R10");
    idle(1, "R10");
    cyc(1'b1, 32'h500, 1'b0, '0, 1'b1, "R10");
    look(32'h500, "R10");
    look(32'h401, "R10");
    // R2: addresses wrap across the top of the space
    fill_run(32'hFFFF_FFFC, 8, "R2");
    look(32'hFFFF_FFFE, "R2");
    idle(7, "R2");
    look(32'h0000_0002, "R2");
    idle(3, "R2");
    look(32'hFFFF_FFFB, "R4");
    idle(1, "R4");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule